// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This block is a multi-cycle integer arithmetic engine for a 32-bit datapath. It offers seven operations: a truncated product, multiply-accumulate, multiply-subtract, unsigned and signed 32x32 long products that return 64 bits, and unsigned and signed division. A caller presents an operation code and its operands with a one-cycle `start` strobe while the unit is idle. It then waits for the one-cycle `done` pulse and takes the result from `res_lo` and, for long products, from `res_hi`.

Products come from a pipelined multiplier whose depth is a parameter. Quotients come from a restoring radix-2 loop that takes one cycle per quotient bit and works on magnitudes. A sign fix-up follows the loop. Two divide inputs have fixed results and complete on the cycle after `start`: a zero divisor, and the single signed quotient that overflows. Neither case ever traps.

Top module: `md_unit`

## Requirements
- R1: Opcode 0 (and the reserved opcode 7) returns the low 32 bits of src_m*src_s on res_lo, with res_hi = 0.
- R2: Opcode 1 returns the low 32 bits of src_n + src_m*src_s on res_lo, with res_hi = 0.
- R3: Opcode 2 returns the low 32 bits of src_n - src_m*src_s on res_lo, with res_hi = 0.
- R4: Opcode 3 returns the unsigned 64-bit product src_m*src_s, with bits 31:0 on res_lo and bits 63:32 on res_hi.
- R5: Opcode 4 returns the two's-complement 64-bit product of src_m and src_s, split in the same way as R4.
- R6: Opcode 5 returns the unsigned quotient src_n/src_m, truncated, on res_lo with res_hi = 0. The remainder is not returned.
- R7: Opcode 6 returns the signed quotient src_n/src_m rounded toward zero, negative when exactly one operand is negative, with res_hi = 0.
- R8: A divide (opcode 5 or 6) with src_m = 0 returns 0 on both result words. done is high on the cycle after start and busy never rises.
- R9: Opcode 6 with src_n = 0x80000000 and src_m = 0xFFFFFFFF returns 0x80000000 with res_hi = 0, completing on the cycle after start without raising busy.
- R10: Any other accepted start raises busy on the next cycle. busy falls in the same cycle that done pulses high for one cycle. The result words change only when done is high.
- R11: start is ignored while busy is high. No extra done is produced and the operation in flight completes with its own result.
- R12: After reset, busy, done, res_lo and res_hi are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only while busy is low |
| op | input | 3 | Operation code, encoding per R1 to R7 |
| src_m | input | W | Multiplicand, or divisor for divides |
| src_s | input | W | Multiplier |
| src_n | input | W | Accumulator for opcodes 1 and 2, dividend for divides |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result words are valid |
| res_lo | output | W | Result, or low word of a long product |
| res_hi | output | W | High word of a long product, else 0 |

## Verification
The bench targets the signed corners first. It checks mixed-sign quotients such as -7/2, where a design that floors instead of truncating returns -4. It checks the most negative dividend, where a faulty magnitude step gives a wrong quotient, and a signed long product with a negative result, where a design that zero-extends its operands leaves res_hi wrong. Zero divisors and the overflowing quotient are checked for their value and for single-cycle completion with busy low; a design that ran them through the loop would pulse done about 34 cycles late and return all ones. A burst of start strobes during a long divide must produce neither an extra done nor a corrupted quotient. Wrap-around in accumulate and subtract is also covered, since a design that kept carry bits would show them in res_hi.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MLA   = 3'd1,
    OP_MLS   = 3'd2,
    OP_UMULL = 3'd3,
    OP_SMULL = 3'd4,
    OP_UDIV  = 3'd5,
    OP_SDIV  = 3'd6,
    OP_RSVD  = 3'd7
  } md_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MUL  = 2'd1,
    S_DIV  = 2'd2
  } md_state_e;

  function automatic logic op_is_div(input md_op_e o);
    return (o == OP_UDIV) || (o == OP_SDIV);
  endfunction

  function automatic logic op_is_long(input md_op_e o);
    return (o == OP_UMULL) || (o == OP_SMULL);
  endfunction

endpackage

// File: rtl/md_mult.sv
module md_mult #(
  parameter int W    = 32,
  parameter int PIPE = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic           valid,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [W:0]  a_q, b_q;
  logic               in_v;
  logic signed [PW-1:0] full;
  logic [PW-1:0]      stage_d [PIPE];
  logic [PIPE-1:0]    stage_v;

  // operand capture, widened by one bit so one multiplier serves both signs
  always_ff @(posedge clk) begin
    if (rst) in_v <= 1'b0;
    else     in_v <= start;
    if (start) begin
      a_q <= {sgn & a[W-1], a};
      b_q <= {sgn & b[W-1], b};
    end
  end

  assign full = PW'(a_q) * PW'(b_q);

  // product delay line, sized for DSP pipelining
  always_ff @(posedge clk) begin
    stage_d[0] <= full;
    for (int i = 1; i < PIPE; i++) stage_d[i] <= stage_d[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) stage_v <= '0;
    else     stage_v <= {stage_v[PIPE-2+((PIPE==1)?1:0):0] & {PIPE{PIPE>1}}, in_v};
  end

  assign valid = stage_v[PIPE-1];
  assign prod  = stage_d[PIPE-1];

endmodule

// File: rtl/md_div.sv
module md_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         sgn,
  output logic         valid,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, q_q, dvs_q;
  logic          neg_q, run_q;
  logic [CW-1:0] cnt_q;

  logic [W:0]    shifted;
  logic          ge;
  logic [W-1:0]  sub, rem_nx, q_nx;

  function automatic logic [W-1:0] mag(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  // one restoring step: shift in the next dividend bit, subtract if it fits
  always_comb begin
    shifted = {rem_q, q_q[W-1]};
    ge      = (shifted >= {1'b0, dvs_q});
    sub     = shifted[W-1:0] - dvs_q;
    rem_nx  = ge ? sub : shifted[W-1:0];
    q_nx    = {q_q[W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      valid <= 1'b0;
      cnt_q <= '0;
      quot  <= '0;
    end else begin
      valid <= 1'b0;
      if (start && !run_q) begin
        rem_q <= '0;
        q_q   <= mag(dividend, sgn);
        dvs_q <= mag(divisor, sgn);
        neg_q <= sgn & (dividend[W-1] ^ divisor[W-1]);
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        q_q   <= q_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          run_q <= 1'b0;
          valid <= 1'b1;
          quot  <= neg_q ? (~q_nx + 1'b1) : q_nx;
        end
      end
    end
  end

endmodule

// File: rtl/md_unit.sv
module md_unit
  import muldiv_pkg::*;
#(
  parameter int W        = 32,
  parameter int MUL_PIPE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] src_m,
  input  logic [W-1:0] src_s,
  input  logic [W-1:0] src_n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  md_state_e    state;
  md_op_e       op_in, op_q;
  logic [W-1:0] acc_q;
  logic         accept, div_op, by_zero, ovf, special;
  logic         mul_v, div_v;
  logic [2*W-1:0] prod;
  logic [W-1:0] quot;
  logic [W-1:0] mul_lo, mul_hi;

  assign op_in   = md_op_e'(op);
  assign accept  = start && (state == S_IDLE);
  assign div_op  = op_is_div(op_in);
  assign by_zero = div_op && (src_m == '0);
  assign ovf     = (op_in == OP_SDIV) && (src_n == MOST_NEG) && (src_m == '1);
  assign special = by_zero || ovf;
  assign busy    = (state != S_IDLE);

  md_mult #(.W(W), .PIPE(MUL_PIPE)) u_mult (
    .clk   (clk),
    .rst   (rst),
    .start (accept && !div_op),
    .a     (src_m),
    .b     (src_s),
    .sgn   (op_in == OP_SMULL),
    .valid (mul_v),
    .prod  (prod)
  );

  md_div #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (accept && div_op && !special),
    .dividend (src_n),
    .divisor  (src_m),
    .sgn      (op_in == OP_SDIV),
    .valid    (div_v),
    .quot     (quot)
  );

  // shape the product for the operation that was accepted
  always_comb begin
    mul_hi = '0;
    case (op_q)
      OP_MLA:   mul_lo = acc_q + prod[W-1:0];
      OP_MLS:   mul_lo = acc_q - prod[W-1:0];
      OP_UMULL,
      OP_SMULL: begin
        mul_lo = prod[W-1:0];
        mul_hi = prod[2*W-1:W];
      end
      default:  mul_lo = prod[W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      res_lo <= '0;
      res_hi <= '0;
      op_q   <= OP_MUL;
      acc_q  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          op_q  <= op_in;
          acc_q <= src_n;
          if (special) begin
            res_lo <= ovf ? MOST_NEG : '0;
            res_hi <= '0;
            done   <= 1'b1;
          end else begin
            state <= div_op ? S_DIV : S_MUL;
          end
        end
        S_MUL: if (mul_v) begin
          res_lo <= mul_lo;
          res_hi <= mul_hi;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        S_DIV: if (div_v) begin
          res_lo <= quot;
          res_hi <= '0;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2:0]   op,
  input logic [W-1:0] src_m,
  input logic [W-1:0] src_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi,
  input logic [2:0]   op_q
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  a_r8_div_zero: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op == 3'd5 || op == 3'd6) && src_m == '0)
    |=> (done && !busy && res_lo == '0 && res_hi == '0));

  a_r9_sdiv_ovf: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 3'd6 && src_n == MOST_NEG && src_m == '1)
    |=> (done && !busy && res_lo == MOST_NEG && res_hi == '0));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_lo) && $stable(res_hi)));

  a_r11_ignore: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(op_q)));

  a_r1_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (done && op_q != 3'd3 && op_q != 3'd4) |-> res_hi == '0);

endmodule

bind md_unit md_unit_chk #(.W(W)) u_md_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .src_m  (src_m),
  .src_n  (src_n),
  .busy   (busy),
  .done   (done),
  .res_lo (res_lo),
  .res_hi (res_hi),
  .op_q   (op_q)
);

// File: tb/test_md_unit.sv
module test_md_unit;
  localparam int W = 32;
  localparam logic [31:0] MN = 32'h8000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start;
  logic [2:0]  op;
  logic [W-1:0] src_m, src_s, src_n;
  logic        busy, done;
  logic [W-1:0] res_lo, res_hi;

  md_unit #(.W(W), .MUL_PIPE(2)) i_md_unit (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .src_m(src_m), .src_s(src_s), .src_n(src_n),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi)
  );

  int    checks = 0, fails = 0;
  bit    finished = 1'b0;
  logic [31:0] q_lo [$];
  logic [31:0] q_hi [$];
  string       q_tag [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] o, input logic [31:0] m, input logic [31:0] s,
                       input logic [31:0] n, output logic [31:0] lo, output logic [31:0] hi);
    logic [63:0] p;
    logic signed [63:0] sa, sb;
    hi = '0;
    case (o)
      3'd1: lo = n + m * s;
      3'd2: lo = n - m * s;
      3'd3: begin p = {32'd0, m} * {32'd0, s}; lo = p[31:0]; hi = p[63:32]; end
      3'd4: begin
        sa = {{32{m[31]}}, m}; sb = {{32{s[31]}}, s};
        p = sa * sb; lo = p[31:0]; hi = p[63:32];
      end
      3'd5: lo = (m == 0) ? 32'd0 : n / m;
      3'd6: begin
        if (m == 0) lo = 32'd0;
        else if (n == MN && m == 32'hFFFF_FFFF) lo = MN;
        else lo = $signed(n) / $signed(m);
      end
      default: lo = m * s;
    endcase
  endtask

  // scoreboard monitor: every done must match the oldest expected item
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_lo.size() == 0) begin
        check(1'b0, "R11 unexpected done", {res_hi, res_lo}, 64'd0);
      end else begin
        logic [31:0] el, eh;
        string t;
        el = q_lo.pop_front(); eh = q_hi.pop_front(); t = q_tag.pop_front();
        check(res_lo == el && res_hi == eh, t, {res_hi, res_lo}, {eh, el});
      end
    end
  end

  task automatic launch(input logic [2:0] o, input logic [31:0] m, input logic [31:0] s,
                        input logic [31:0] n, input string tag);
    logic [31:0] el, eh;
    model(o, m, s, n, el, eh);
    while (busy) @(negedge clk);
    q_lo.push_back(el); q_hi.push_back(eh); q_tag.push_back(tag);
    start = 1'b1; op = o; src_m = m; src_s = s; src_n = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] m, input logic [31:0] s,
                       input logic [31:0] n, input string tag);
    bit spec;
    spec = ((o == 3'd5 || o == 3'd6) && m == 0) || (o == 3'd6 && n == MN && m == 32'hFFFF_FFFF);
    launch(o, m, s, n, tag);
    if (spec) check(!busy && done, {tag, " one-cycle finish"}, {62'd0, busy, done}, 64'd1);
    else      check(busy && !done, "R10 busy after start", {62'd0, busy, done}, 64'd2);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; op = '0; src_m = '0; src_s = '0; src_n = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && res_lo == 0 && res_hi == 0, "R12 reset state",
          {res_hi, res_lo}, 64'd0);

    issue(3'd0, 32'd3, 32'd5, 32'd0, "R1 small");
    issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd9, "R1 wrap");
    issue(3'd0, 32'h1234_5678, 32'h9ABC_DEF0, 32'd0, "R1 mixed");
    issue(3'd7, 32'd7, 32'd6, 32'd1, "R1 reserved opcode");
    issue(3'd1, 32'd7, 32'd9, 32'd100, "R2 mla");
    issue(3'd1, 32'hFFFF_FFFF, 32'd2, 32'd5, "R2 mla wrap");
    issue(3'd2, 32'd3, 32'd4, 32'd10, "R3 mls negative");
    issue(3'd2, 32'h0001_0000, 32'h0001_0000, 32'd1, "R3 mls wrap");
    issue(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, "R4 umull max");
    issue(3'd3, MN, 32'd2, 32'd0, "R4 umull carry");
    issue(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, "R5 smull -1*-1");
    issue(3'd4, 32'hFFFF_FFFE, 32'd3, 32'd0, "R5 smull negative");
    issue(3'd4, MN, MN, 32'd0, "R5 smull most negative");
    issue(3'd5, 32'd7, 32'd0, 32'd100, "R6 udiv");
    issue(3'd5, 32'd1, 32'd0, 32'hFFFF_FFFF, "R6 udiv by one");
    issue(3'd5, 32'd9, 32'd0, 32'd5, "R6 udiv small");
    issue(3'd5, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, "R6 udiv equal");
    issue(3'd5, 32'd3, 32'd0, MN, "R6 udiv high bit");
    issue(3'd6, 32'd2, 32'd0, 32'hFFFF_FFF9, "R7 -7/2");
    issue(3'd6, 32'hFFFF_FFFE, 32'd0, 32'd7, "R7 7/-2");
    issue(3'd6, 32'hFFFF_FFFE, 32'd0, 32'hFFFF_FFF9, "R7 -7/-2");
    issue(3'd6, 32'd2, 32'd0, MN, "R7 most negative /2");
    issue(3'd6, 32'h7FFF_FFFF, 32'd0, MN, "R7 most negative /max");
    issue(3'd5, 32'd0, 32'd0, 32'd1234, "R8 udiv zero");
    issue(3'd6, 32'd0, 32'd0, 32'hFFFF_0000, "R8 sdiv zero");
    issue(3'd6, 32'hFFFF_FFFF, 32'd0, MN, "R9 overflow");
    issue(3'd6, 32'hFFFF_FFFF, 32'd0, MN, "R9 overflow back-to-back");

    // R11: strobes during a long divide must not start anything
    launch(3'd5, 32'd13, 32'd0, 32'd1_000_000, "R11 divide in flight");
    repeat (4) begin
      start = 1'b1; op = 3'd0; src_m = 32'd99; src_s = 32'd99; src_n = 32'd0;
      @(negedge clk);
    end
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    check(q_lo.size() == 0, "R11 queue drained", 64'(q_lo.size()), 64'd0);

    for (int k = 0; k < 40; k++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      issue(o, $urandom(), $urandom(), $urandom(),
            (o >= 3'd5 && o <= 3'd6) ? "R7 random divide" : "R5 random product");
    end

    repeat (4) @(negedge clk);
    check(q_lo.size() == 0 && !busy, "R10 all results seen", 64'(q_lo.size()), 64'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule